// File: doc/BRIEF.md
# Pixel Hit Time-Stamp Logic

This block is the digital back end of one pixel in a gas-detector readout array. It takes the discriminator output, or an injected test pulse in its place, and turns a hit into a 12-bit record. A fine drift time is counted on a local fast clock of roughly 560 MHz from the accepted hit edge up to the next edge of the 40 MHz array clock. A time-over-threshold count is kept in slow-clock bins. A latency count then holds the record for a programmable number of slow periods. The pixel has a single hit buffer. If nobody reads it before the latency runs out, the buffer frees itself.

All registers run on the fast clock. The slow clock and the hit source are sampled through two flops each, and the slow clock's rising edge becomes a one-fast-cycle "slow tick". The fine counter is a 4-bit shift-register sequence that visits all 16 codes. Its state is decoded to a binary step count at the output. The readout side is a valid/ready pair, with `rd_strobe` in the ready role. A transfer completes at a slow tick where both are high, and after it the buffer is empty. While `out_valid` is high the fine and ToT fields do not change. The latency field keeps advancing until the word is read or expires. There is no back-pressure on the hit side: a hit that arrives while the buffer is occupied is dropped.

Top module: `pix_stamp`

## Requirements
- R1: After reset `out_valid` and `fast_or` are 0 and `word_out` is all zeros.
- R2: With `tp_en` high the hit source is `test_pulse` and `disc_in` has no effect. With `tp_en` low the hit source is `disc_in`.
- R3: While `mask_en` is high no hit is accepted: `fast_or` stays low and no word becomes valid.
- R4: `word_out[11:8]` gives the fine time in binary. It is the number of fast cycles the fine counter advanced between the accepted hit edge and the first following slow tick, saturating at 15.
- R5: `word_out[7:4]` gives the ToT. It is the number of slow ticks seen while the sampled hit stays high after acceptance, saturating at 15, and it never decreases during a hit.
- R6: `fast_or` goes high one fast cycle after a hit edge is accepted and falls once the hit's end is sampled. It is never high together with `out_valid`.
- R7: `out_valid` rises once the hit has ended and the fine time is frozen. While it stays high, bits 11:4 of `word_out` stay constant.
- R8: A hit edge that arrives while the buffer is occupied is ignored. It changes neither the word nor `fast_or`.
- R9: A slow tick with `out_valid` and `rd_strobe` both high clears `out_valid` in the next fast cycle and frees the buffer.
- R10: `word_out[3:0]` counts the slow ticks since capture. A slow tick with this count at or above `lat_cfg` and no strobe clears the buffer, so a word lives for `lat_cfg`+1 slow ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | 40 MHz array clock, sampled as data |
| clk_fast | input | 1 | Local fast clock that clocks all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_in | input | 1 | Discriminator output |
| test_pulse | input | 1 | Injected test pulse |
| mask_en | input | 1 | Blocks hit recording when high |
| tp_en | input | 1 | Selects the test pulse as hit source |
| lat_cfg | input | 4 | Latency limit in slow ticks |
| rd_strobe | input | 1 | Readout strobe (ready), taken at slow ticks |
| word_out | output | 12 | {fine time, ToT, latency} record |
| out_valid | output | 1 | Record held and valid |
| fast_or | output | 1 | Hit being recorded (self-trigger) |

## Verification
On every fast cycle the assertions check several things. The fine and ToT fields are frozen while the word is valid. ToT does not fall during a hit. The self-trigger and valid flags are exclusive. A masked input never raises the self-trigger. A strobed tick or an expired latency count always drops `out_valid` on the next cycle. Only the bench scenarios can show that the fine time and ToT actually match randomly timed hits against two unrelated clocks. The same holds for showing that a second pulse during occupancy is lost, that test-pulse selection works, and how long an unread word survives.

// File: rtl/pix_pkg.sv
`timescale 1ns/1ps
package pix_pkg;
  localparam int FINE_W = 4;
  localparam int TOT_W  = 4;
  localparam int LAT_W  = 4;
endpackage

// File: rtl/pix_sync.sv
`timescale 1ns/1ps
// Two-flop sampling of asynchronous levels into the fast domain, with rise detect.
module pix_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign lvl[i]  = s1;
    assign rise[i] = s1 & ~s2;
  end
endmodule

// File: rtl/pix_fine_lfsr.sv
`timescale 1ns/1ps
// Full-period (2**W states) shift-register counter with binary decode.
// Supported widths: 3, 4, 5.
module pix_fine_lfsr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] bin
);
  localparam int TAP_A  = W - 1;
  localparam int TAP_B  = (W == 5) ? 2 : W - 2;
  localparam int STATES = 1 << W;

  function automatic logic [W-1:0] step(input logic [W-1:0] q);
    logic fb;
    fb = q[TAP_A] ^ q[TAP_B] ^ (q[W-2:0] == '0);
    return {q[W-2:0], fb};
  endfunction

  function automatic logic [W-1:0] final_state();
    logic [W-1:0] s;
    s = '0;
    for (int i = 1; i < STATES; i++) s = step(s);
    return s;
  endfunction

  localparam logic [W-1:0] LAST = final_state();

  logic [W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  st <= '0;
    else if (load)               st <= '0;
    else if (adv && st != LAST)  st <= step(st);
  end

  always_comb begin
    logic [W-1:0] s;
    s   = '0;
    bin = '0;
    for (int i = 0; i < STATES; i++) begin
      if (s == st) bin = i[W-1:0];
      s = step(s);
    end
  end
endmodule

// File: rtl/pix_sat_cnt.sv
`timescale 1ns/1ps
module pix_sat_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= '0;
    else if (inc && q != '1)    q <= q + 1'b1;
  end
endmodule

// File: rtl/pix_stamp.sv
`timescale 1ns/1ps
module pix_stamp
  import pix_pkg::*;
#(
  parameter int FW = FINE_W,
  parameter int TW = TOT_W,
  parameter int LW = LAT_W
) (
  input  logic              clk_slow,
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic              disc_in,
  input  logic              test_pulse,
  input  logic              mask_en,
  input  logic              tp_en,
  input  logic [LW-1:0]     lat_cfg,
  input  logic              rd_strobe,
  output logic [FW+TW+LW-1:0] word_out,
  output logic              out_valid,
  output logic              fast_or
);
  localparam int WORD_W = FW + TW + LW;

  logic          hit_src;
  logic [1:0]    smp_lvl, smp_rise;
  logic          slow_tick, hit_lvl, hit_rise;
  logic          busy, running, tot_on, valid_q;
  logic          accept, capture, expire, rd_clr, release_buf;
  logic [FW-1:0] fine_q;
  logic [TW-1:0] tot_q;
  logic [LW-1:0] lat_q;

  assign hit_src = ~mask_en & (tp_en ? test_pulse : disc_in);

  pix_sync #(.N(2)) u_sync (
    .clk  (clk_fast),
    .rst_n(rst_n),
    .d    ({hit_src, clk_slow}),
    .lvl  (smp_lvl),
    .rise (smp_rise)
  );

  assign slow_tick = smp_rise[0];
  assign hit_lvl   = smp_lvl[1];
  assign hit_rise  = smp_rise[1];

  assign accept      = ~busy & hit_rise;
  assign capture     = busy & ~running & ~tot_on & ~valid_q;
  assign rd_clr      = valid_q & slow_tick & rd_strobe;
  assign expire      = valid_q & slow_tick & (lat_q >= lat_cfg);
  assign release_buf = rd_clr | expire;

  pix_fine_lfsr #(.W(FW)) u_fine (
    .clk  (clk_fast),
    .rst_n(rst_n),
    .load (accept),
    .adv  (running & ~slow_tick),
    .bin  (fine_q)
  );

  pix_sat_cnt #(.W(TW)) u_tot (
    .clk  (clk_fast),
    .rst_n(rst_n),
    .clr  (accept),
    .inc  (tot_on & hit_lvl & slow_tick),
    .q    (tot_q)
  );

  pix_sat_cnt #(.W(LW)) u_lat (
    .clk  (clk_fast),
    .rst_n(rst_n),
    .clr  (accept),
    .inc  (valid_q & slow_tick & ~release_buf),
    .q    (lat_q)
  );

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      running <= 1'b0;
      tot_on  <= 1'b0;
      valid_q <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      running <= 1'b1;
      tot_on  <= 1'b1;
    end else begin
      if (running && slow_tick) running <= 1'b0;
      if (tot_on && !hit_lvl)   tot_on  <= 1'b0;
      if (capture)              valid_q <= 1'b1;
      if (release_buf) begin
        valid_q <= 1'b0;
        busy    <= 1'b0;
      end
    end
  end

  assign word_out  = {fine_q, tot_q, lat_q};
  assign out_valid = valid_q;
  assign fast_or   = tot_on;

  logic unused_w;
  assign unused_w = (WORD_W == 0);
endmodule

// File: rtl/pix_stamp_chk.sv
`timescale 1ns/1ps
module pix_stamp_chk #(
  parameter int TW = 4,
  parameter int LW = 4,
  parameter int WW = 12
) (
  input logic          clk_fast,
  input logic          rst_n,
  input logic          mask_en,
  input logic          rd_strobe,
  input logic          slow_tick,
  input logic [LW-1:0] lat_cfg,
  input logic [WW-1:0] word_out,
  input logic          out_valid,
  input logic          fast_or
);
  // R7
  held_fields_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> $stable(word_out[WW-1:LW]));

  // R5
  tot_monotone_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    fast_or && $past(fast_or) |-> word_out[LW+TW-1:LW] >= $past(word_out[LW+TW-1:LW]));

  // R6
  or_excl_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_valid |-> !fast_or);

  // R3
  mask_block_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(mask_en, 2) && !$past(fast_or) |-> !fast_or);

  // R9
  read_clear_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_valid && slow_tick && rd_strobe |=> !out_valid);

  // R10
  lat_expire_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    out_valid && slow_tick && (word_out[LW-1:0] >= lat_cfg) |=> !out_valid);
endmodule

bind pix_stamp pix_stamp_chk #(.TW(TW), .LW(LW), .WW(WORD_W)) u_chk (
  .clk_fast (clk_fast),
  .rst_n    (rst_n),
  .mask_en  (mask_en),
  .rd_strobe(rd_strobe),
  .slow_tick(slow_tick),
  .lat_cfg  (lat_cfg),
  .word_out (word_out),
  .out_valid(out_valid),
  .fast_or  (fast_or)
);

// File: tb/sim_pix_stamp.sv
`timescale 1ns/1ps
module sim_pix_stamp;
  localparam int  FAST_PER  = 10;
  localparam real SLOW_HALF = 70.5;

  logic clk_fast = 1'b0, clk_slow = 1'b0, rst_n = 1'b0;
  logic disc_in = 1'b0, test_pulse = 1'b0, mask_en = 1'b0, tp_en = 1'b0;
  logic rd_strobe = 1'b0;
  logic [3:0]  lat_cfg = 4'd3;
  logic [11:0] word_out;
  logic out_valid, fast_or;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  pix_stamp u0 (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
    .disc_in(disc_in), .test_pulse(test_pulse), .mask_en(mask_en),
    .tp_en(tp_en), .lat_cfg(lat_cfg), .rd_strobe(rd_strobe),
    .word_out(word_out), .out_valid(out_valid), .fast_or(fast_or)
  );

  always #(FAST_PER/2) clk_fast = ~clk_fast;
  initial begin
    #0.3;
    forever #(SLOW_HALF) clk_slow = ~clk_slow;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: the hit and slow clock as seen at fast edges.
  bit ms1, ms2, mh1, mh2;
  bit m_busy, m_run, m_ton, m_valid;
  int m_cnt, m_tot, m_lat;

  always @(posedge clk_fast) begin
    bit tk, rs, cap, rel;
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; mh1 = 0; mh2 = 0;
      m_busy = 0; m_run = 0; m_ton = 0; m_valid = 0;
      m_cnt = 0; m_tot = 0; m_lat = 0;
    end else begin
      tk  = ms1 && !ms2;
      rs  = mh1 && !mh2;
      cap = m_busy && !m_run && !m_ton && !m_valid;
      rel = m_valid && tk && (rd_strobe || m_lat >= int'(lat_cfg));
      if (!m_busy) begin
        if (rs) begin
          m_busy = 1; m_run = 1; m_ton = 1;
          m_cnt = 0; m_tot = 0; m_lat = 0;
        end
      end else begin
        if (m_run) begin
          if (tk) m_run = 0;
          else if (m_cnt < 15) m_cnt++;
        end
        if (m_ton) begin
          if (!mh1) m_ton = 0;
          else if (tk && m_tot < 15) m_tot++;
        end
        if (rel) begin
          m_valid = 0; m_busy = 0;
        end else if (m_valid && tk) m_lat++;
        if (cap) m_valid = 1;
      end
      ms2 = ms1; ms1 = clk_slow;
      mh2 = mh1; mh1 = !mask_en && (tp_en ? test_pulse : disc_in);
    end
  end

  always @(negedge clk_fast) begin
    if (rst_n && !done) begin
      check(out_valid == m_valid, "R7 valid", int'(out_valid), int'(m_valid));
      check(fast_or == m_ton, "R6 fast_or", int'(fast_or), int'(m_ton));
      if (m_valid && out_valid) begin
        check(int'(word_out[11:8]) == m_cnt, "R4 fine", int'(word_out[11:8]), m_cnt);
        check(int'(word_out[7:4]) == m_tot, "R5 tot", int'(word_out[7:4]), m_tot);
        check(int'(word_out[3:0]) == m_lat, "R10 lat", int'(word_out[3:0]), m_lat);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_fast);
  endtask

  // which: 0 disc_in, 1 test_pulse
  task automatic pulse(input int which, input int len);
    @(negedge clk_fast); #2;
    if (which == 0) disc_in = 1'b1; else test_pulse = 1'b1;
    repeat (len) @(negedge clk_fast);
    #2;
    if (which == 0) disc_in = 1'b0; else test_pulse = 1'b0;
  endtask

  task automatic wait_valid();
    while (!out_valid) @(negedge clk_fast);
  endtask

  task automatic wait_idle();
    cyc(20);
    while (out_valid) @(negedge clk_fast);
    cyc(2);
  endtask

  task automatic strobe();
    @(negedge clk_fast); #2 rd_strobe = 1'b1;
    repeat (16) @(negedge clk_fast);
    #2 rd_strobe = 1'b0;
  endtask

  initial begin
    int seen, len;
    logic [7:0] held;
    cyc(4);
    #2 rst_n = 1'b1;
    cyc(2);
    // R1
    check(!out_valid, "R1 valid", int'(out_valid), 0);
    check(!fast_or, "R1 fast_or", int'(fast_or), 0);
    check(word_out == 12'd0, "R1 word", int'(word_out), 0);

    // R2: test pulse mode ignores the discriminator
    tp_en = 1'b1;
    fork
      pulse(0, 30);
      begin seen = 0; repeat (40) begin @(negedge clk_fast); if (fast_or) seen++; end end
    join
    check(seen == 0, "R2 disc ignored", seen, 0);
    check(!out_valid, "R2 no word", int'(out_valid), 0);
    fork
      pulse(1, 30);
      begin seen = 0; repeat (40) begin @(negedge clk_fast); if (fast_or) seen++; end end
    join
    check(seen > 0, "R2 test pulse seen", seen, 1);
    wait_valid();
    check(out_valid, "R2 word captured", int'(out_valid), 1);
    wait_idle();
    tp_en = 1'b0;

    // R3: masked pixel
    mask_en = 1'b1;
    fork
      pulse(0, 40);
      begin seen = 0; repeat (60) begin @(negedge clk_fast); if (fast_or || out_valid) seen++; end end
    join
    check(seen == 0, "R3 masked", seen, 0);
    cyc(3);
    mask_en = 1'b0;
    cyc(3);

    // R5: ToT saturation on a long hit
    lat_cfg = 4'd15;
    pulse(0, 260);
    wait_valid();
    check(word_out[7:4] == 4'd15, "R5 saturation", int'(word_out[7:4]), 15);

    // R8: a second hit during occupancy is dropped
    held = word_out[11:4];
    fork
      pulse(0, 20);
      begin seen = 0; repeat (30) begin @(negedge clk_fast); if (fast_or) seen++; end end
    join
    check(seen == 0, "R8 fast_or quiet", seen, 0);
    check(word_out[11:4] == held, "R8 word kept", int'(word_out[11:4]), int'(held));
    check(out_valid, "R8 still valid", int'(out_valid), 1);

    // R9: readout clears before latency expiry
    strobe();
    cyc(2);
    check(!out_valid, "R9 cleared by strobe", int'(out_valid), 0);
    wait_idle();

    // R10: expiry after lat_cfg+1 slow ticks
    lat_cfg = 4'd2;
    pulse(0, 25);
    wait_valid();
    len = 0;
    while (out_valid) begin @(negedge clk_fast); len++; end
    check(len >= 28 && len <= 46, "R10 hold length", len, 37);
    wait_idle();

    // Random hit timing against both clocks
    for (int k = 0; k < 120; k++) begin
      lat_cfg = 4'($urandom_range(0, 15));
      cyc($urandom_range(0, 20));
      len = ($urandom_range(0, 9) == 0) ? $urandom_range(150, 260) : $urandom_range(1, 60);
      pulse(0, len);
      cyc(20);
      if ($urandom_range(0, 1) == 1) begin
        cyc($urandom_range(0, 60));
        strobe();
      end
      wait_idle();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_fast);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule